// File: doc/BRIEF.md
# Prioritized Multi-Source Interrupt Controller

This block gathers up to 64 interrupt request lines and presents one request line to a processor. Each line gets a two-bit trigger type (low level, high level, falling edge, rising edge) and a three-bit priority. An edge seen on an edge-typed line is held in a per-line latch until software clears it. A line is pending while its level is active, or while its latch is set.

Among the pending lines whose priority is above a global threshold, the controller selects the one with the highest priority. When priorities tie, the lowest line number wins. A global enable gates the processor request. A status register returns the selected line number, or a "nothing pending" flag. Software uses a plain synchronous register port: a write strobe with an address and data, and a read-data register that follows the address one cycle later.

Line 0 is reserved and never raises a request. Every input passes through a two-flop synchroniser before detection, so the request lines may be asynchronous to the clock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Line 0 is never pending and is never reported, whatever its type, priority and input.
- R2: The type register for line 16m+j is at word address 8+m, bits 2j+1:2j. Type 00 makes the line pending while its input is low. Type 01 makes it pending while its input is high.
- R3: Type 11 latches a rising input transition and type 10 latches a falling one. The latch keeps the line pending after the input returns, until the latch is cleared.
- R4: The priority of line 2k is at word address 32+k, bits 2:0, and the priority of line 2k+1 is in bits 10:8 of the same register. Priority 0 means the line can never be selected.
- R5: The enable register is at word address 0, bit 0. While it is 0, `cpu_irq` stays low and the status register reports nothing pending.
- R6: The threshold register is at word address 1, bits 2:0. A pending line can be selected only when its priority is strictly greater than the threshold.
- R7: Clear commands for lines 0 to 31 are written to word address 4, and for lines 32 to 63 to word address 5. Within a register, the field in bits 8:0 serves the lower 16 lines of its group and the field in bits 24:16 serves the upper 16. Bit 8 of a field is the enable, and bits 3:0 are the line index within the 16. A field whose enable is 0 clears nothing.
- R8: The status register at word address 2 has bit 16 set when no line is selected. Otherwise bit 16 is clear and bits 5:0 hold the selected line number.
- R9: The selected line has the highest priority among the qualifying lines. On a tie, the lowest-numbered line wins.
- R10: After reset, every line has type 00 and priority 0, and the enable and threshold are 0.
- R11: Writing a type value that differs from a line's current one clears that line's edge latch. Rewriting the same value leaves the latch alone.
- R12: `reg_rdata` shows the register addressed in the previous cycle. `cpu_irq` and the status follow a register write after one cycle, and follow an input change after at most four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the address in the previous cycle |
| cpu_irq | output | 1 | Request to the processor |

## Verification
An input change goes through two synchroniser flops. An edge line then passes through its latch, and finally the registered output stage. So `cpu_irq` and the status are due at most four cycles after an input change, and one cycle after a register write. Register read data is due one cycle after its address is presented. The bench therefore waits six cycles after every stimulus before it samples `cpu_irq`. It then reads the status through the register port and samples that value one cycle after the address. All sampling happens on the falling edge, away from the edge that updates the registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W      = 32;
  localparam int LVL_W       = 3;
  localparam int A_ENABLE    = 0;
  localparam int A_THRESH    = 1;
  localparam int A_STATUS    = 2;
  localparam int A_CLR_BASE  = 4;
  localparam int A_MODE_BASE = 8;
  localparam int A_PRIO_BASE = 32;
  localparam int NONE_BIT    = 16;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] ff1_q;
  logic [W-1:0] ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= d;
      ff2_q <= ff1_q;
    end
  end

  assign q = ff2_q;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int NSRC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   s,
  input  logic [2*NSRC-1:0] mode,
  input  logic [NSRC-1:0]   clr,
  input  logic [NSRC-1:0]   mode_wr,
  output logic [NSRC-1:0]   req
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] lat_q;
  logic [NSRC-1:0] lat_d;
  logic [NSRC-1:0] edge_now;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic is_edge;
    logic pol;
    assign is_edge = mode[2*i+1];
    assign pol     = mode[2*i];

    if (i == 0) begin : g_unused
      assign edge_now[i] = 1'b0;
      assign lat_d[i]    = 1'b0;
      assign req[i]      = 1'b0;
    end else begin : g_used
      assign edge_now[i] = is_edge &
                           (pol ? (s[i] & ~prev_q[i]) : (~s[i] & prev_q[i]));
      assign lat_d[i]    = edge_now[i] | (lat_q[i] & ~clr[i] & ~mode_wr[i]);
      assign req[i]      = is_edge ? lat_q[i] : (s[i] == pol);
    end

    // R7
    clr_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !edge_now[i]) |=> !lat_q[i]);
    // R11
    mode_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr[i] && !edge_now[i]) |=> !lat_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= s;
      lat_q  <= lat_d;
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NSRC  = 64,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       req,
  input  logic [LVL_W*NSRC-1:0] prio,
  input  logic [LVL_W-1:0]      thr,
  output logic                  any,
  output logic [IDX_W-1:0]      idx
);
  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    any      = 1'b0;
    idx      = '0;
    best_lvl = '0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (req[i] && (prio[LVL_W*i +: LVL_W] > thr) &&
          (prio[LVL_W*i +: LVL_W] >= best_lvl)) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        best_lvl = prio[LVL_W*i +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_irq
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int NMODE = NSRC / 16;
  localparam int NPRIO = NSRC / 2;
  localparam int NCLR  = NSRC / 32;

  logic                  en_q, en_d;
  logic [LVL_W-1:0]      thr_q, thr_d;
  logic [2*NSRC-1:0]     mode_q, mode_d;
  logic [LVL_W*NSRC-1:0] prio_q, prio_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic                  irq_q, irq_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [NSRC-1:0]       clr, mode_wr;
  logic [NSRC-1:0]       sync_s;
  logic [NSRC-1:0]       req;
  logic                  arb_any;
  logic [IDX_W-1:0]      arb_idx;
  logic [LVL_W-1:0]      sel_lvl;

  irqc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_s)
  );

  irqc_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .s(sync_s), .mode(mode_q),
    .clr(clr), .mode_wr(mode_wr), .req(req)
  );

  irqc_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .req(req), .prio(prio_q), .thr(thr_q), .any(arb_any), .idx(arb_idx)
  );

  // register write decode
  always_comb begin
    en_d    = en_q;
    thr_d   = thr_q;
    mode_d  = mode_q;
    prio_d  = prio_q;
    clr     = '0;
    mode_wr = '0;
    if (reg_we) begin
      if (int'(reg_addr) == A_ENABLE) en_d = reg_wdata[0];
      if (int'(reg_addr) == A_THRESH) thr_d = reg_wdata[LVL_W-1:0];
      for (int c = 0; c < NCLR; c++) begin
        if (int'(reg_addr) == A_CLR_BASE + c) begin
          for (int h = 0; h < 2; h++) begin
            if (reg_wdata[16*h+8])
              clr[32*c + 16*h + int'(reg_wdata[16*h +: 4])] = 1'b1;
          end
        end
      end
      for (int m = 0; m < NMODE; m++) begin
        if (int'(reg_addr) == A_MODE_BASE + m) begin
          mode_d[32*m +: 32] = reg_wdata;
          for (int j = 0; j < 16; j++) begin
            if (reg_wdata[2*j +: 2] != mode_q[32*m + 2*j +: 2])
              mode_wr[16*m + j] = 1'b1;
          end
        end
      end
      for (int k = 0; k < NPRIO; k++) begin
        if (int'(reg_addr) == A_PRIO_BASE + k) begin
          prio_d[LVL_W*(2*k)   +: LVL_W] = reg_wdata[0 +: LVL_W];
          prio_d[LVL_W*(2*k+1) +: LVL_W] = reg_wdata[8 +: LVL_W];
        end
      end
    end
  end

  // read mux and output stage next state
  always_comb begin
    rdata_d = '0;
    if (int'(reg_addr) == A_ENABLE) rdata_d[0] = en_q;
    if (int'(reg_addr) == A_THRESH) rdata_d[LVL_W-1:0] = thr_q;
    if (int'(reg_addr) == A_STATUS) begin
      rdata_d[NONE_BIT]    = ~irq_q;
      rdata_d[IDX_W-1:0]   = idx_q;
    end
    for (int m = 0; m < NMODE; m++) begin
      if (int'(reg_addr) == A_MODE_BASE + m) rdata_d = mode_q[32*m +: 32];
    end
    for (int k = 0; k < NPRIO; k++) begin
      if (int'(reg_addr) == A_PRIO_BASE + k) begin
        rdata_d[0 +: LVL_W] = prio_q[LVL_W*(2*k)   +: LVL_W];
        rdata_d[8 +: LVL_W] = prio_q[LVL_W*(2*k+1) +: LVL_W];
      end
    end
    irq_d = en_q & arb_any;
    idx_d = irq_d ? arb_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      thr_q   <= '0;
      mode_q  <= '0;
      prio_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      en_q    <= en_d;
      thr_q   <= thr_d;
      mode_q  <= mode_d;
      prio_q  <= prio_d;
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
      idx_q   <= idx_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign cpu_irq   = irq_q;
  assign sel_lvl   = prio_q[LVL_W*int'(arb_idx) +: LVL_W];

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !cpu_irq);
  // R1
  line0_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (idx_q != '0));
  // R6
  above_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_any |-> (sel_lvl > thr_q));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;
  logic [1:0] mode_sh [N];
  logic [2:0] prio_sh [N];

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_mode(input int s, input logic [1:0] m);
    logic [31:0] w;
    mode_sh[s] = m;
    w = '0;
    for (int j = 0; j < 16; j++) w[2*j +: 2] = mode_sh[(s/16)*16 + j];
    wr(8 + s/16, w);
  endtask

  task automatic set_prio(input int s, input logic [2:0] l);
    logic [31:0] w;
    prio_sh[s] = l;
    w = '0;
    w[2:0]  = prio_sh[(s/2)*2];
    w[10:8] = prio_sh[(s/2)*2 + 1];
    wr(32 + s/2, w);
  endtask

  // exp_src 0 means nothing selected
  task automatic expect_sel(input string r, input int exp_src);
    logic [31:0] st;
    repeat (6) @(negedge clk);
    chk(r, {31'd0, cpu_irq}, {31'd0, exp_src != 0});
    rd(2, st);
    chk(r, st, (exp_src == 0) ? 32'h0001_0000 : 32'(exp_src));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin mode_sh[i] = 2'b00; prio_sh[i] = 3'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 cpu_irq", {31'd0, cpu_irq}, 32'd0);
    rd(0, d);  chk("R10 enable", d, 32'd0);
    rd(1, d);  chk("R10 thresh", d, 32'd0);
    rd(8, d);  chk("R10 mode", d, 32'd0);
    rd(63, d); chk("R10 prio", d, 32'd0);
    rd(2, d);  chk("R10 R8 status", d, 32'h0001_0000);

    // R4 layout readback
    set_prio(6, 3'd5); set_prio(7, 3'd2);
    rd(35, d); chk("R4 prio layout", d, 32'h0000_0205);
    set_prio(6, 3'd0); set_prio(7, 3'd0);

    // R5 disabled: pending line gives nothing
    set_mode(3, 2'b01); set_prio(3, 3'd7);
    expect_sel("R5 disabled", 0);
    wr(0, 32'd1);
    expect_sel("R5 enabled", 3);
    set_prio(3, 3'd0); set_mode(3, 2'b00);

    // R2 R12 level sweep over every line
    for (int i = 1; i < N; i++) begin
      set_mode(i, 2'b01);
      set_prio(i, 3'(1 + i % 7));
      expect_sel("R2 high level on", i);
      irq_in[i] = 1'b0;
      expect_sel("R2 high level off", 0);
      set_prio(i, 3'd0);
      set_mode(i, 2'b00);
      set_prio(i, 3'd4);
      expect_sel("R2 low level on", i);
      irq_in[i] = 1'b1;
      expect_sel("R2 low level off", 0);
      set_prio(i, 3'd0);
    end

    // R1 line 0 never reported
    set_mode(0, 2'b01); set_prio(0, 3'd7);
    expect_sel("R1 line0", 0);
    set_prio(0, 3'd0); set_mode(0, 2'b00);

    // R4 R6 priority versus threshold sweep on line 33
    set_mode(33, 2'b01);
    for (int l = 0; l < 8; l++) begin
      set_prio(33, 3'(l));
      for (int t = 0; t < 8; t++) begin
        wr(1, 32'(t));
        expect_sel("R6 R4 thresh", (l > t) ? 33 : 0);
      end
    end
    wr(1, 32'd0); set_prio(33, 3'd0); set_mode(33, 2'b00);

    // R9 ties and highest priority
    set_mode(5, 2'b01); set_mode(9, 2'b01);
    set_prio(5, 3'd3); set_prio(9, 3'd3);
    expect_sel("R9 tie lowest", 5);
    set_prio(9, 3'd4);
    expect_sel("R9 highest", 9);
    wr(1, 32'd4);
    expect_sel("R6 equal level blocked", 0);
    wr(1, 32'd3);
    expect_sel("R6 R9 above", 9);
    wr(1, 32'd0);
    set_prio(5, 3'd0); set_prio(9, 3'd0);
    set_mode(5, 2'b00); set_mode(9, 2'b00);

    // R3 R7 rising edge on line 40
    set_mode(40, 2'b11); set_prio(40, 3'd4);
    irq_in[40] = 1'b0;
    expect_sel("R3 rising no edge yet", 0);
    irq_in[40] = 1'b1;
    expect_sel("R3 rising latched", 40);
    irq_in[40] = 1'b0;
    expect_sel("R3 rising held", 40);
    wr(5, 32'h0000_0008);
    expect_sel("R7 no enable no clear", 40);
    wr(5, 32'h0000_0108);
    expect_sel("R7 cleared low field", 0);
    irq_in[40] = 1'b1;
    expect_sel("R3 rising again", 40);
    wr(5, 32'h0000_0108);
    set_prio(40, 3'd0); set_mode(40, 2'b00);

    // R3 R7 falling edge on line 20
    set_mode(20, 2'b10); set_prio(20, 3'd2);
    irq_in[20] = 1'b0;
    expect_sel("R3 falling latched", 20);
    irq_in[20] = 1'b1;
    expect_sel("R3 falling held", 20);
    wr(4, 32'h0000_0104);
    expect_sel("R7 other field no clear", 20);
    wr(4, 32'h0104_0000);
    expect_sel("R7 cleared high field", 0);
    set_prio(20, 3'd0); set_mode(20, 2'b00);

    // R11 type change clears latch on line 50
    set_mode(50, 2'b11); set_prio(50, 3'd6);
    irq_in[50] = 1'b0;
    repeat (4) @(negedge clk);
    irq_in[50] = 1'b1;
    expect_sel("R11 latched", 50);
    set_mode(50, 2'b11);
    expect_sel("R11 same value keeps", 50);
    set_mode(50, 2'b10);
    expect_sel("R11 new value clears", 0);
    set_prio(50, 3'd0); set_mode(50, 2'b00);

    // R5 enable off drops output
    set_mode(12, 2'b01); set_prio(12, 3'd1);
    expect_sel("R5 on", 12);
    wr(0, 32'd0);
    expect_sel("R5 off", 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule